// File: doc/BRIEF.md
# Drift-Compensating Baseline Tracker

The tracker holds a 16-bit reference level for each sensing channel and reports how far each new acquisition result sits from that reference, as a signed count. While a channel is not detecting, its reference creeps toward the raw signal one count at a time. Upward and downward creep each have their own rate. While a channel is detecting, the reference is frozen, so a genuine touch is not absorbed into the baseline.

A long-detection guard runs for each channel. If a detection lasts longer than the configured maximum on-time, the reference is snapped to the latest sample and a one-cycle recalibration pulse is issued for that channel only. All timing is counted in burst ticks supplied from outside. A sleep-enabled flag selects how many ticks make up one drift or timeout unit.

Top module: `drift_baseline_tracker`

## Requirements
- R1: The first valid sample a channel receives after reset is loaded into its reference directly, so its deviation reads 0 after that sample.
- R2: Each channel's deviation is its latest valid sample minus its reference. It is given as 16-bit two's complement and saturates at 32767 and -32768.
- R3: With no detection and the latest sample above the reference, the reference rises by one count each time the upward rate timer expires. The timer expires every (up_rate+1) drift units.
- R4: With no detection and the latest sample below the reference, the reference falls by one count each time the downward rate timer expires. The timer expires every (dn_rate+1) drift units.
- R5: A tick prescaler counts burst ticks from reset. With sleep enabled, one drift unit is one tick. With sleep disabled, one drift unit is 16 ticks, and the unit ends on every tick whose count since reset is a multiple of 16.
- R6: A rate value of 255 disables drift in that direction.
- R7: While a channel's detect input is high, its reference does not drift.
- R8: If detect stays high continuously, recalibration fires after (hold_lim+1)×16 ticks with sleep enabled, or (hold_lim+1)×256 ticks with sleep disabled. Timeout units end on ticks whose count since reset is a multiple of 16 or 256 respectively. On firing, the reference takes the latest sample and recal_o pulses high for one cycle.
- R9: A hold limit of 255 disables the timeout, and that channel never recalibrates.
- R10: The timeout count restarts from zero whenever detect goes low.
- R11: A recalibration or detection on one channel does not change the other channel's reference or recal output.
- R12: After reset every deviation is 0 and no recal pulse is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | NUM_CH*16 | Raw samples, channel c at bits [16c+15:16c] |
| smp_vld_i | input | NUM_CH | Sample-valid strobes, one per channel |
| det_i | input | NUM_CH | Detection-active flags, one per channel |
| tick_i | input | 1 | Burst tick, one cycle wide |
| sleep_en_i | input | 1 | Sleep enabled; selects the fine timebase |
| up_rate_i | input | 8 | Upward drift rate, 255 disables |
| dn_rate_i | input | 8 | Downward drift rate, 255 disables |
| hold_lim_i | input | NUM_CH*8 | Per-channel maximum on-time, 255 disables |
| dev_o | output | NUM_CH*16 | Signed saturated deviation per channel |
| recal_o | output | NUM_CH | One-cycle recalibration pulse per channel |

## Verification
The drift logic is tried three ways: with a sample above the reference, with a sample below it, and with a sample held at a distance while detect is high. Together these separate the upward path, the downward path and the freeze. The bench counts ticks to the exact cycle of the first step, in both timebases, which exposes an off-by-one in a rate timer or a wrong prescale divisor. For the timeout, the bench compares a detection held without a break, one interrupted after a full timeout unit, and one with the disabling limit. It also runs a two-channel case in which only one channel detects. Extreme sample/reference pairs check that the deviation clamps instead of wrapping.

// File: rtl/dbt_pkg.sv
// Package: shared widths and the saturating deviation helper.
// Assumes unsigned samples; deviation is two's complement of equal width.
package dbt_pkg;
    parameter int SMP_W  = 16;
    parameter int RATE_W = 8;

    // Difference a-b clamped to the signed range of SMP_W bits.
    function automatic logic [SMP_W-1:0] sat_diff(input logic [SMP_W-1:0] a,
                                                 input logic [SMP_W-1:0] b);
        logic [SMP_W:0] d;
        d = {1'b0, a} - {1'b0, b};
        if (d[SMP_W] != d[SMP_W-1])
            return d[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
        return d[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/dbt_timebase.sv
// Tick prescaler: derives drift and timeout unit strobes from burst ticks.
// Assumes FINE_DIV and COARSE_DIV are powers of two, COARSE_DIV >= FINE_DIV.
module dbt_timebase #(
    parameter int FINE_DIV   = 16,
    parameter int COARSE_DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sleep_en_i,
    output logic drift_unit_o,
    output logic hold_unit_o
);
    localparam int PRE_W  = $clog2(COARSE_DIV);
    localparam int FINE_W = $clog2(FINE_DIV);

    logic [PRE_W-1:0] pre_q;
    logic             fine_end;
    logic             coarse_end;

    // Count ticks since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_i) pre_q <= pre_q + PRE_W'(1);
    end

    // Unit boundaries fall on the last tick of each fine or coarse span.
    always_comb begin
        fine_end     = tick_i && (pre_q[FINE_W-1:0] == {FINE_W{1'b1}});
        coarse_end   = tick_i && (pre_q == {PRE_W{1'b1}});
        drift_unit_o = sleep_en_i ? tick_i   : fine_end;
        hold_unit_o  = sleep_en_i ? fine_end : coarse_end;
    end
endmodule

// File: rtl/dbt_rate_timer.sv
// Drift rate timer: strobes step_o once every (rate_i+1) unit strobes.
// Assumes the all-ones rate value means "never step".
module dbt_rate_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              step_o
);
    logic [RATE_W-1:0] cnt_q;
    logic              off;

    // Step decision from the unit strobe and the elapsed count.
    always_comb begin
        off    = (rate_i == {RATE_W{1'b1}});
        step_o = unit_i && !off && (cnt_q >= rate_i);
    end

    // Advance the interval count; wrap on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || off) cnt_q <= '0;
        else if (unit_i)   cnt_q <= step_o ? '0 : cnt_q + RATE_W'(1);
    end
endmodule

// File: rtl/dbt_channel.sv
// One channel: reference register, latest sample, maximum-on timer.
// Assumes step and unit strobes are single-cycle and shared by all channels.
module dbt_channel #(
    parameter int SMP_W  = 16,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic              vld_i,
    input  logic              det_i,
    input  logic              up_step_i,
    input  logic              dn_step_i,
    input  logic              hold_unit_i,
    input  logic [RATE_W-1:0] hold_lim_i,
    output logic [SMP_W-1:0]  dev_o,
    output logic              recal_o
);
    logic [SMP_W-1:0]  ref_q;
    logic [SMP_W-1:0]  live_q;
    logic              init_q;
    logic [RATE_W-1:0] hold_q;
    logic              fire;
    logic [SMP_W-1:0]  load_val;

    // Timeout decision and the value a reload takes.
    always_comb begin
        fire     = init_q && det_i && hold_unit_i &&
                   (hold_lim_i != {RATE_W{1'b1}}) && (hold_q >= hold_lim_i);
        load_val = vld_i ? smp_i : live_q;
        dev_o    = dbt_pkg::sat_diff(live_q, ref_q);
    end

    // Latest sample, first-load flag and recalibration pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            init_q  <= 1'b0;
            recal_o <= 1'b0;
        end else begin
            if (vld_i) live_q <= smp_i;
            if (vld_i) init_q <= 1'b1;
            recal_o <= fire;
        end
    end

    // Reference: first load, then reload on timeout, else one-count drift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (!init_q) begin
            if (vld_i) ref_q <= smp_i;
        end else if (fire) begin
            ref_q <= load_val;
        end else if (!det_i) begin
            if (up_step_i && (live_q > ref_q))      ref_q <= ref_q + SMP_W'(1);
            else if (dn_step_i && (live_q < ref_q)) ref_q <= ref_q - SMP_W'(1);
        end
    end

    // Maximum-on timer: counts units while detecting, restarts when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_i || !init_q) hold_q <= '0;
        else if (hold_unit_i) begin
            if (fire)                            hold_q <= '0;
            else if (hold_q != {RATE_W{1'b1}})   hold_q <= hold_q + RATE_W'(1);
        end
    end
endmodule

// File: rtl/drift_baseline_tracker.sv
// Top: shared timebase and rate timers feeding one tracker per channel.
// Assumes tick_i is a single-cycle strobe; rates are common to all channels.
module drift_baseline_tracker #(
    parameter int NUM_CH     = 2,
    parameter int SMP_W      = dbt_pkg::SMP_W,
    parameter int RATE_W     = dbt_pkg::RATE_W,
    parameter int FINE_DIV   = 16,
    parameter int COARSE_DIV = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*SMP_W-1:0]  smp_i,
    input  logic [NUM_CH-1:0]        smp_vld_i,
    input  logic [NUM_CH-1:0]        det_i,
    input  logic                     tick_i,
    input  logic                     sleep_en_i,
    input  logic [RATE_W-1:0]        up_rate_i,
    input  logic [RATE_W-1:0]        dn_rate_i,
    input  logic [NUM_CH*RATE_W-1:0] hold_lim_i,
    output logic [NUM_CH*SMP_W-1:0]  dev_o,
    output logic [NUM_CH-1:0]        recal_o
);
    logic drift_unit;
    logic hold_unit;
    logic up_step;
    logic dn_step;

    dbt_timebase #(.FINE_DIV(FINE_DIV), .COARSE_DIV(COARSE_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_en_i(sleep_en_i),
        .drift_unit_o(drift_unit), .hold_unit_o(hold_unit)
    );

    dbt_rate_timer #(.RATE_W(RATE_W)) u_up (
        .clk(clk), .rst_n(rst_n), .unit_i(drift_unit), .rate_i(up_rate_i), .step_o(up_step)
    );

    dbt_rate_timer #(.RATE_W(RATE_W)) u_dn (
        .clk(clk), .rst_n(rst_n), .unit_i(drift_unit), .rate_i(dn_rate_i), .step_o(dn_step)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbt_channel #(.SMP_W(SMP_W), .RATE_W(RATE_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .smp_i(smp_i[c*SMP_W +: SMP_W]), .vld_i(smp_vld_i[c]), .det_i(det_i[c]),
            .up_step_i(up_step), .dn_step_i(dn_step), .hold_unit_i(hold_unit),
            .hold_lim_i(hold_lim_i[c*RATE_W +: RATE_W]),
            .dev_o(dev_o[c*SMP_W +: SMP_W]), .recal_o(recal_o[c])
        );
    end
endmodule

// File: rtl/dbt_checker.sv
// Checker: temporal properties on the tracker's ports, bound to the top.
module dbt_checker #(
    parameter int NUM_CH = 2,
    parameter int SMP_W  = 16,
    parameter int RATE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        smp_vld_i,
    input logic [NUM_CH-1:0]        det_i,
    input logic [NUM_CH*RATE_W-1:0] hold_lim_i,
    input logic [NUM_CH*SMP_W-1:0]  dev_o,
    input logic [NUM_CH-1:0]        recal_o
);
    logic [NUM_CH*SMP_W-1:0] prev_q;

    // Keep last cycle's deviations for step-size comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= dev_o;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic signed [SMP_W:0] dd;
        always_comb dd = $signed({dev_o[c*SMP_W+SMP_W-1], dev_o[c*SMP_W +: SMP_W]}) -
                         $signed({prev_q[c*SMP_W+SMP_W-1], prev_q[c*SMP_W +: SMP_W]});

        // R3
        drift_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !smp_vld_i[c] |=> (recal_o[c] || (dd >= -1 && dd <= 1)));

        // R7
        det_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (det_i[c] && !smp_vld_i[c]) |=> (recal_o[c] || dd == 0));

        // R8
        recal_zero_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
            recal_o[c] |-> (dev_o[c*SMP_W +: SMP_W] == '0));

        // R8
        recal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            recal_o[c] |=> !recal_o[c]);

        // R9
        recal_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            recal_o[c] |-> ($past(hold_lim_i[c*RATE_W +: RATE_W]) != {RATE_W{1'b1}}));

        // R10
        recal_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
            recal_o[c] |-> $past(det_i[c]));
    end
endmodule

bind drift_baseline_tracker dbt_checker #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .det_i(det_i),
    .hold_lim_i(hold_lim_i), .dev_o(dev_o), .recal_o(recal_o)
);

// File: tb/drift_baseline_tracker_test.sv
`timescale 1ns/1ps
module drift_baseline_tracker_test;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC*16-1:0] smp = '0;
    logic [NC-1:0] vld = '0;
    logic [NC-1:0] det = '0;
    logic          tick = 1'b0;
    logic          sleep_en = 1'b1;
    logic [7:0]    up_rate = 8'hFF;
    logic [7:0]    dn_rate = 8'hFF;
    logic [NC*8-1:0] hold_lim = {NC{8'hFF}};
    logic [NC*16-1:0] dev;
    logic [NC-1:0] recal;
    logic [NC-1:0] seen;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    drift_baseline_tracker uut (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld), .det_i(det),
        .tick_i(tick), .sleep_en_i(sleep_en), .up_rate_i(up_rate), .dn_rate_i(dn_rate),
        .hold_lim_i(hold_lim), .dev_o(dev), .recal_o(recal)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int devof(input int ch);
        return int'($signed(dev[ch*16 +: 16]));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = '0; det = '0; tick = 1'b0; seen = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input int ch, input int val);
        smp[ch*16 +: 16] = 16'(val);
        vld[ch] = 1'b1;
        @(negedge clk);
        vld[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            seen = seen | recal;
            @(negedge clk);
            seen = seen | recal;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R12 dev0", devof(0), 0);
        check("R12 dev1", devof(1), 0);
        check("R12 recal", int'(recal), 0);
    endtask

    task automatic t_first_load();
        do_reset();
        put(0, 1000);
        check("R1 first load", devof(0), 0);
        put(0, 1010);
        check("R2 positive dev", devof(0), 10);
        put(0, 990);
        check("R2 negative dev", devof(0), -10);
    endtask

    task automatic t_up_drift();
        sleep_en = 1'b1; up_rate = 8'd2; dn_rate = 8'hFF; hold_lim = {NC{8'hFF}};
        do_reset();
        put(0, 1000); put(0, 1010);
        ticks(2);
        check("R3 before step", devof(0), 10);
        ticks(1);
        check("R3 first step", devof(0), 9);
        ticks(3);
        check("R3 second step", devof(0), 8);
    endtask

    task automatic t_dn_drift();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'd0;
        do_reset();
        put(0, 1000); put(0, 995);
        ticks(1);
        check("R4 first step", devof(0), -4);
        ticks(1);
        check("R4 second step", devof(0), -3);
    endtask

    task automatic t_disable();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'd0;
        do_reset();
        put(0, 1000); put(0, 1020);
        ticks(40);
        check("R6 up disabled", devof(0), 20);
    endtask

    task automatic t_slow_base();
        sleep_en = 1'b0; up_rate = 8'd0; dn_rate = 8'hFF;
        do_reset();
        put(0, 1000); put(0, 1010);
        ticks(15);
        check("R5 no step at 15", devof(0), 10);
        ticks(1);
        check("R5 step at 16", devof(0), 9);
        ticks(16);
        check("R5 step at 32", devof(0), 8);
    endtask

    task automatic t_freeze();
        sleep_en = 1'b1; up_rate = 8'd0; dn_rate = 8'd0; hold_lim = {NC{8'hFF}};
        do_reset();
        put(0, 1000); put(0, 1030);
        det[0] = 1'b1;
        ticks(20);
        check("R7 frozen", devof(0), 30);
        det[0] = 1'b0;
        ticks(1);
        check("R7 resumes", devof(0), 29);
    endtask

    task automatic t_hold_sleep();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {8'hFF, 8'd1};
        do_reset();
        put(0, 1000); put(0, 1050);
        det[0] = 1'b1;
        ticks(31);
        check("R8 no recal at 31", int'(seen[0]), 0);
        check("R8 dev kept", devof(0), 50);
        ticks(1);
        check("R8 recal at 32", int'(seen[0]), 1);
        check("R8 ref reloaded", devof(0), 0);
        put(0, 1060);
        check("R8 ref equals sample", devof(0), 10);
        det[0] = 1'b0;
    endtask

    task automatic t_hold_fast();
        sleep_en = 1'b0; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {8'hFF, 8'd0};
        do_reset();
        put(0, 1000); put(0, 1050);
        det[0] = 1'b1;
        ticks(255);
        check("R8 fast no recal at 255", int'(seen[0]), 0);
        ticks(1);
        check("R8 fast recal at 256", int'(seen[0]), 1);
        det[0] = 1'b0;
    endtask

    task automatic t_restart();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {8'hFF, 8'd1};
        do_reset();
        put(0, 1000); put(0, 1050);
        det[0] = 1'b1;
        ticks(16);
        det[0] = 1'b0;
        @(negedge clk);
        det[0] = 1'b1;
        ticks(31);
        check("R10 restarted no recal", int'(seen[0]), 0);
        ticks(1);
        check("R10 recal after full span", int'(seen[0]), 1);
        det[0] = 1'b0;
    endtask

    task automatic t_infinite();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {NC{8'hFF}};
        do_reset();
        put(0, 1000); put(0, 1050);
        det[0] = 1'b1;
        ticks(600);
        check("R9 never recal", int'(seen[0]), 0);
        check("R9 dev kept", devof(0), 50);
        det[0] = 1'b0;
    endtask

    task automatic t_indep();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {8'd0, 8'd0};
        do_reset();
        put(0, 1000); put(0, 1050);
        put(1, 2000); put(1, 2040);
        det = 2'b01;
        ticks(16);
        check("R11 ch0 recal", int'(seen[0]), 1);
        check("R11 ch0 dev", devof(0), 0);
        check("R11 ch1 no recal", int'(seen[1]), 0);
        check("R11 ch1 dev kept", devof(1), 40);
        det = '0;
    endtask

    task automatic t_sat();
        sleep_en = 1'b1; up_rate = 8'hFF; dn_rate = 8'hFF; hold_lim = {NC{8'hFF}};
        do_reset();
        put(0, 0); put(0, 65535);
        put(1, 65535); put(1, 0);
        check("R2 clamp high", devof(0), 32767);
        check("R2 clamp low", devof(1), -32768);
    endtask

    initial begin
        t_reset();
        t_first_load();
        t_up_drift();
        t_dn_drift();
        t_disable();
        t_slow_base();
        t_freeze();
        t_hold_sleep();
        t_hold_fast();
        t_restart();
        t_infinite();
        t_indep();
        t_sat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule